// File: doc/BRIEF.md
# Single-Wire Bus Master with Serial-Identifier Reader

This block controls a single-wire, open-drain bus shared with one slave device. It never drives the line high: it either pulls the line low or releases it and lets an external pull-up raise it. Every bus event is a time slot whose phases are counted in microseconds. A prescaler divides the system clock down to a 1 µs tick, and the tick restarts at the beginning of each slot.

A single `start` pulse launches a fixed transaction with no further help from the host. The block issues a reset slot and samples the presence answer. It then sends the identifier-read command one bit at a time, least significant bit first. Last, it runs 64 read slots. From these it collects a family byte, six identifier bytes and a check byte, and it verifies the check byte against a CRC-8 of the seven bytes before it. When the transaction ends, `done` pulses, `busy` falls and the results stay on the outputs until the next start.

Top module: `owire_id_reader`

## Requirements
- R1: After reset, and at all times while `busy` is low, `bus_drive_low` is 0 and the line is released. After reset, `busy`, `done`, `no_device`, `crc_ok` and all result buses are 0.
- R2: The reset slot drives the line low for exactly 480·CLK_PER_US clock cycles. The next slot's low phase starts no sooner than 480 µs after release.
- R3: The line is sampled, through a two-flop synchronizer, 70 µs after the reset slot releases it. A high sample sets `no_device` to 1 and a low sample sets it to 0.
- R4: The command byte (default 0x33) follows the reset slot as eight write slots, LSB first. A 1 bit is 6 µs low and then at least 64 µs released. A 0 bit is 60 µs low and then at least 10 µs released.
- R5: Each read slot is 6 µs low and then released. The bit is the line level 9 µs after release. The next slot starts no sooner than 64 µs after release.
- R6: Read bits fill each byte LSB first. The first read byte goes to `family`. The next six go to `dev_id`, with the first of them in `dev_id[7:0]`. The eighth goes to `check_byte`.
- R7: `crc_ok` is 1 when `check_byte` equals the CRC-8 of `family` and the six ID bytes. The CRC uses polynomial x^8+x^5+x^4+1, bit-reflected, with initial value 0, and takes the bytes in bus order, LSB first.
- R8: Exactly 73 slots make up each transaction (1 reset, 8 write, 64 read), even when no device answers. In that case the results are whatever the released line reads (all ones) and `no_device` is 1.
- R9: `start` while `busy` is low raises `busy` on the next cycle. `start` while `busy` is high has no effect on slots or results.
- R10: `done` is a one-cycle pulse in the same cycle `busy` falls. The results are valid then and stay unchanged while `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one identifier-read transaction |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_drive_low | output | 1 | Pad enable: 1 pulls the line low, 0 releases it |
| bus_in | input | 1 | Raw line level from the pad |
| no_device | output | 1 | No presence answer seen after reset slot |
| family | output | 8 | First byte read |
| dev_id | output | 48 | Six identifier bytes, first in bits 7:0 |
| check_byte | output | 8 | Received check byte |
| crc_ok | output | 1 | Check byte matches computed CRC |

## Verification
A wrong phase counter or slot kind shows up at `bus_drive_low` in the very slot where it occurs, as a low pulse of the wrong length or a release gap that is too short. Every slot edge is compared with a reference schedule, so such a fault is caught within one slot. A slot counter that is off by one shows up as a missing or extra slot, or as a stray `done`, when the transaction ends. Faults in the byte shifter, the placement of bytes or the CRC stay hidden until `done`, and then appear in `family`, `dev_id`, `check_byte` or `crc_ok`. The device model supplies patterns that separate these faults: mixed bits, all zeros, all ones, and a corrupted check byte.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [1:0] {
        SLOT_RST = 2'd0,
        SLOT_W0  = 2'd1,
        SLOT_W1  = 2'd2,
        SLOT_RD  = 2'd3
    } slot_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_REL  = 2'd2,
        PH_TAIL = 2'd3
    } slot_phase_e;

    // One step of the reflected x^8+x^5+x^4+1 CRC, fed one bus bit.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic b);
        logic [7:0] s;
        s = {1'b0, crc[7:1]};
        if (crc[0] ^ b) s = s ^ 8'h8C;
        return s;
    endfunction

endpackage

// File: rtl/owire_tick.sv
module owire_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    output logic level
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb sr_d = {sr_q[STAGES-2:0], pad};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign level = sr_q[STAGES-1];
endmodule

// File: rtl/owire_slot.sv
module owire_slot
    import owire_pkg::*;
#(
    parameter int T_RST_LOW  = 480,
    parameter int T_RST_REL  = 70,
    parameter int T_RST_TAIL = 410,
    parameter int T_W1_LOW   = 6,
    parameter int T_W1_REL   = 64,
    parameter int T_W0_LOW   = 60,
    parameter int T_W0_REL   = 10,
    parameter int T_RD_LOW   = 6,
    parameter int T_RD_REL   = 9,
    parameter int T_RD_TAIL  = 55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  slot_kind_e kind,
    input  logic       tick,
    input  logic       line,
    output logic       tick_clr,
    output logic       drive_low,
    output logic       slot_done,
    output logic       slot_bit
);
    localparam int T_SUM = T_RST_LOW + T_RST_REL + T_RST_TAIL + T_W1_LOW + T_W1_REL
                         + T_W0_LOW + T_W0_REL + T_RD_LOW + T_RD_REL + T_RD_TAIL;
    localparam int US_W = $clog2(T_SUM + 1);

    localparam logic [US_W-1:0] RST_LO = US_W'(T_RST_LOW - 1);
    localparam logic [US_W-1:0] RST_RL = US_W'(T_RST_REL - 1);
    localparam logic [US_W-1:0] RST_TL = US_W'(T_RST_TAIL - 1);
    localparam logic [US_W-1:0] W1_LO  = US_W'(T_W1_LOW - 1);
    localparam logic [US_W-1:0] W1_RL  = US_W'(T_W1_REL - 1);
    localparam logic [US_W-1:0] W0_LO  = US_W'(T_W0_LOW - 1);
    localparam logic [US_W-1:0] W0_RL  = US_W'(T_W0_REL - 1);
    localparam logic [US_W-1:0] RD_LO  = US_W'(T_RD_LOW - 1);
    localparam logic [US_W-1:0] RD_RL  = US_W'(T_RD_REL - 1);
    localparam logic [US_W-1:0] RD_TL  = US_W'(T_RD_TAIL - 1);

    typedef struct packed {
        slot_phase_e     phase;
        slot_kind_e      kind;
        logic [US_W-1:0] us;
        logic            drive;
        logic            done;
        logic            rx;
    } slot_t;

    slot_t q, d;

    logic [US_W-1:0] lo_end, rel_end, tail_end;
    logic            has_tail;

    // Phase lengths for the latched slot kind (last microsecond index).
    always_comb begin
        lo_end   = RD_LO;
        rel_end  = RD_RL;
        tail_end = RD_TL;
        has_tail = 1'b1;
        unique case (q.kind)
            SLOT_RST: begin lo_end = RST_LO; rel_end = RST_RL; tail_end = RST_TL; end
            SLOT_W1:  begin lo_end = W1_LO;  rel_end = W1_RL;  has_tail = 1'b0; end
            SLOT_W0:  begin lo_end = W0_LO;  rel_end = W0_RL;  has_tail = 1'b0; end
            default:  begin lo_end = RD_LO;  rel_end = RD_RL;  tail_end = RD_TL; end
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (go) begin
                    d.phase = PH_LOW;
                    d.kind  = kind;
                    d.us    = '0;
                    d.drive = 1'b1;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (q.us == lo_end) begin
                        d.phase = PH_REL;
                        d.us    = '0;
                        d.drive = 1'b0;
                    end else begin
                        d.us = q.us + 1'b1;
                    end
                end
            end
            PH_REL: begin
                if (tick) begin
                    if (q.us == rel_end) begin
                        d.rx = line;
                        d.us = '0;
                        if (has_tail) begin
                            d.phase = PH_TAIL;
                        end else begin
                            d.phase = PH_IDLE;
                            d.done  = 1'b1;
                        end
                    end else begin
                        d.us = q.us + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.us == tail_end) begin
                        d.phase = PH_IDLE;
                        d.us    = '0;
                        d.done  = 1'b1;
                    end else begin
                        d.us = q.us + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_clr  = (q.phase == PH_IDLE);
    assign drive_low = q.drive;
    assign slot_done = q.done;
    assign slot_bit  = q.rx;
endmodule

// File: rtl/owire_id_reader.sv
module owire_id_reader
    import owire_pkg::*;
#(
    parameter int         CLK_PER_US  = 125,
    parameter int         ID_BYTES    = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ROM_CMD     = 8'h33,
    parameter int         T_RST_LOW   = 480,
    parameter int         T_RST_REL   = 70,
    parameter int         T_RST_TAIL  = 410,
    parameter int         T_W1_LOW    = 6,
    parameter int         T_W1_REL    = 64,
    parameter int         T_W0_LOW    = 60,
    parameter int         T_W0_REL    = 10,
    parameter int         T_RD_LOW    = 6,
    parameter int         T_RD_REL    = 9,
    parameter int         T_RD_TAIL   = 55
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  busy,
    output logic                  done,
    output logic                  bus_drive_low,
    input  logic                  bus_in,
    output logic                  no_device,
    output logic [7:0]            family,
    output logic [8*ID_BYTES-1:0] dev_id,
    output logic [7:0]            check_byte,
    output logic                  crc_ok
);
    localparam int ID_W      = 8 * ID_BYTES;
    localparam int RD_BYTES  = ID_BYTES + 2;
    localparam int N_SLOTS   = 1 + 8 + 8 * RD_BYTES;
    localparam int IDX_W     = $clog2(N_SLOTS);
    localparam int BI_W      = IDX_W - 3;
    localparam logic [IDX_W-1:0] FIRST_RD = IDX_W'(9);
    localparam logic [IDX_W-1:0] LAST_WR  = IDX_W'(7);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);
    localparam logic [BI_W-1:0]  CHK_BI   = BI_W'(RD_BYTES - 1);

    typedef struct packed {
        logic             busy;
        logic             go;
        slot_kind_e       kind;
        logic [IDX_W-1:0] idx;
        logic [7:0]       sh;
        logic [7:0]       crc;
        logic [7:0]       fam;
        logic [ID_W-1:0]  id;
        logic [7:0]       chk;
        logic             nodev;
        logic             crcok;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic tick, tick_clr, line, slot_done, slot_bit;

    owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad(bus_in), .level(line)
    );

    owire_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
    );

    owire_slot #(
        .T_RST_LOW(T_RST_LOW), .T_RST_REL(T_RST_REL), .T_RST_TAIL(T_RST_TAIL),
        .T_W1_LOW(T_W1_LOW),   .T_W1_REL(T_W1_REL),
        .T_W0_LOW(T_W0_LOW),   .T_W0_REL(T_W0_REL),
        .T_RD_LOW(T_RD_LOW),   .T_RD_REL(T_RD_REL),   .T_RD_TAIL(T_RD_TAIL)
    ) u_slot (
        .clk(clk), .rst_n(rst_n), .go(q.go), .kind(q.kind), .tick(tick),
        .line(line), .tick_clr(tick_clr), .drive_low(bus_drive_low),
        .slot_done(slot_done), .slot_bit(slot_bit)
    );

    logic [IDX_W-1:0] rd_pos;
    logic [BI_W-1:0]  rd_byte;
    logic [7:0]       sh_n;
    logic [7:0]       crc_n;

    assign rd_pos  = q.idx - FIRST_RD;
    assign rd_byte = rd_pos[IDX_W-1:3];
    assign sh_n    = {slot_bit, q.sh[7:1]};
    assign crc_n   = crc8_step(q.crc, slot_bit);

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.go   = 1'b1;
                d.kind = SLOT_RST;
                d.idx  = '0;
                d.crc  = '0;
            end
        end else if (slot_done) begin
            // Absorb the result of the slot that just ended.
            if (q.idx == '0) begin
                d.nodev = slot_bit;
            end else if (q.idx >= FIRST_RD) begin
                d.sh  = sh_n;
                d.crc = crc_n;
                if (rd_pos[2:0] == 3'd7) begin
                    if (rd_byte == '0) d.fam = sh_n;
                    else if (rd_byte == CHK_BI) d.chk = sh_n;
                    for (int k = 0; k < ID_BYTES; k++) begin
                        if (rd_byte == BI_W'(k + 1)) d.id[k*8 +: 8] = sh_n;
                    end
                end
            end
            // Launch the next slot or close the transaction.
            if (q.idx == LAST_IDX) begin
                d.busy  = 1'b0;
                d.done  = 1'b1;
                d.crcok = (crc_n == 8'h00);
            end else begin
                d.idx = q.idx + 1'b1;
                d.go  = 1'b1;
                if (q.idx <= LAST_WR) d.kind = ROM_CMD[q.idx[2:0]] ? SLOT_W1 : SLOT_W0;
                else                  d.kind = SLOT_RD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = q.busy;
    assign done       = q.done;
    assign no_device  = q.nodev;
    assign family     = q.fam;
    assign dev_id     = q.id;
    assign check_byte = q.chk;
    assign crc_ok     = q.crcok;
endmodule

// File: rtl/owire_id_reader_chk.sv
module owire_id_reader_chk #(
    parameter int CLK_PER_US = 125,
    parameter int T_RST_LOW  = 480,
    parameter int ID_W       = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            bus_drive_low,
    input logic            no_device,
    input logic            crc_ok,
    input logic [7:0]      family,
    input logic [ID_W-1:0] dev_id,
    input logic [7:0]      check_byte
);
    localparam int unsigned LOW_LIMIT = T_RST_LOW * CLK_PER_US;

    int unsigned low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             low_run_q <= 0;
        else if (bus_drive_low) low_run_q <= low_run_q + 1;
        else                    low_run_q <= 0;
    end

    AST_DRIVE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_low |-> busy); // R1

    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_low |-> (low_run_q < LOW_LIMIT)); // R2

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && !bus_drive_low)); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(dev_id) && $stable(family) &&
        $stable(check_byte) && $stable(no_device) && $stable(crc_ok))); // R10

endmodule

bind owire_id_reader owire_id_reader_chk #(
    .CLK_PER_US(CLK_PER_US), .T_RST_LOW(T_RST_LOW), .ID_W(8 * ID_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .bus_drive_low(bus_drive_low), .no_device(no_device), .crc_ok(crc_ok),
    .family(family), .dev_id(dev_id), .check_byte(check_byte)
);

// File: tb/owire_id_reader_test.sv
module owire_id_reader_test;
    localparam int P     = 3;
    localparam int SLACK = 4;
    localparam int NSLOT = 73;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, bus_drive_low, no_device, crc_ok, bus_in;
    logic [7:0]  family, check_byte;
    logic [47:0] dev_id;
    logic        dev_pull = 1'b0;

    always #4 clk = ~clk;

    assign bus_in = !(bus_drive_low || dev_pull);

    owire_id_reader #(.CLK_PER_US(P)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .bus_drive_low(bus_drive_low), .bus_in(bus_in), .no_device(no_device),
        .family(family), .dev_id(dev_id), .check_byte(check_byte), .crc_ok(crc_ok)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference schedule: per slot, exact low length and minimum release length (us).
    int    exp_low[$];
    int    exp_high[$];
    string exp_tag[$];
    int    slots_seen = 0;
    int    done_cnt = 0;
    bit    mon_on = 1'b0;

    task automatic build_schedule(input logic [7:0] cmd);
        exp_low.delete(); exp_high.delete(); exp_tag.delete();
        exp_low.push_back(480); exp_high.push_back(480); exp_tag.push_back("R2");
        for (int i = 0; i < 8; i++) begin
            if (cmd[i]) begin exp_low.push_back(6);  exp_high.push_back(64); end
            else        begin exp_low.push_back(60); exp_high.push_back(10); end
            exp_tag.push_back("R4");
        end
        for (int i = 0; i < 64; i++) begin
            exp_low.push_back(6); exp_high.push_back(64); exp_tag.push_back("R5");
        end
    endtask

    // Cycle-by-cycle monitor against the schedule.
    bit    prev_drv = 1'b0;
    int    run = 0;
    bit    pend_high = 1'b0;
    int    cur_high = 0;
    string cur_tag = "";

    always @(negedge clk) begin
        if (mon_on) begin
            chk(!(bus_drive_low && !busy), "R1", "line pulled while idle", 64'(bus_drive_low), 64'd0);
            if (bus_drive_low != prev_drv) begin
                if (prev_drv) begin
                    slots_seen++;
                    if (exp_low.size() == 0) begin
                        chk(1'b0, "R8", "unexpected extra slot", 64'(slots_seen), 64'(NSLOT));
                    end else begin
                        int el;
                        el = exp_low.pop_front();
                        cur_high = exp_high.pop_front();
                        cur_tag = exp_tag.pop_front();
                        chk(run == el * P, cur_tag, "low length (cycles)", 64'(run), 64'(el * P));
                        pend_high = 1'b1;
                    end
                end else if (pend_high) begin
                    chk(run >= cur_high * P && run <= cur_high * P + SLACK, cur_tag,
                        "release length (cycles)", 64'(run), 64'(cur_high * P));
                    pend_high = 1'b0;
                end
                run = 1;
            end else begin
                run++;
            end
            prev_drv = bus_drive_low;
            if (done) begin
                done_cnt++;
                if (pend_high)
                    chk(run >= cur_high * P && run <= cur_high * P + SLACK, cur_tag,
                        "final release before done", 64'(run), 64'(cur_high * P));
                pend_high = 1'b0;
                chk(slots_seen == NSLOT && exp_low.size() == 0, "R8", "slot count at done",
                    64'(slots_seen), 64'(NSLOT));
            end
        end
    end

    // Behavioural slave device.
    bit          dev_present = 1'b0;
    logic [63:0] dev_rom = '0;
    logic [7:0]  dev_cmd = '0;
    int          dslot = 100;

    initial begin
        forever begin
            @(negedge clk);
            if (bus_drive_low) begin
                int w;
                w = 0;
                if (dev_present && dslot >= 8 && dslot < 72 && !dev_rom[dslot - 8]) dev_pull = 1'b1;
                while (bus_drive_low) begin w++; @(negedge clk); end
                if (w >= 200 * P) begin
                    dslot = 0;
                    if (dev_present) begin
                        repeat (30 * P) @(negedge clk);
                        dev_pull = 1'b1;
                        repeat (100 * P) @(negedge clk);
                        dev_pull = 1'b0;
                    end
                end else if (dslot < 8) begin
                    dev_cmd[dslot] = (w < 15 * P);
                    dslot++;
                end else begin
                    if (dev_pull) begin
                        repeat (18 * P - w) @(negedge clk);
                        dev_pull = 1'b0;
                    end
                    dslot++;
                end
            end
        end
    end

    function automatic logic [7:0] ref_crc(input logic [55:0] v);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic m;
            m = c[0] ^ v[i];
            c = c >> 1;
            if (m) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    task automatic run_seq(input bit present, input logic [7:0] fam, input logic [47:0] id,
                           input bit good_chk, input bit poke);
        logic [7:0]  chkv, e_fam, e_chk;
        logic [47:0] e_id;
        bit          e_ok;
        int          d0;
        chkv = ref_crc({id, fam}) ^ (good_chk ? 8'h00 : 8'h40);
        dev_present = present;
        dev_rom = {chkv, id, fam};
        dev_cmd = '0;
        build_schedule(8'h33);
        slots_seen = 0;
        d0 = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (5000) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(busy == 1'b1, "R9", "busy kept after start while busy", 64'(busy), 64'd1);
        end
        while (!done) @(negedge clk);
        e_fam = present ? fam  : 8'hFF;
        e_id  = present ? id   : 48'hFFFF_FFFF_FFFF;
        e_chk = present ? chkv : 8'hFF;
        e_ok  = (ref_crc({e_id, e_fam}) == e_chk);
        chk(busy == 1'b0, "R10", "busy low with done", 64'(busy), 64'd0);
        chk(no_device == !present, "R3", "presence flag", 64'(no_device), 64'(!present));
        chk(family == e_fam, "R6", "family byte", 64'(family), 64'(e_fam));
        chk(dev_id == e_id, "R6", "identifier", 64'(dev_id), 64'(e_id));
        chk(check_byte == e_chk, "R6", "check byte", 64'(check_byte), 64'(e_chk));
        chk(crc_ok == e_ok, "R7", "crc flag", 64'(crc_ok), 64'(e_ok));
        chk(dev_cmd == 8'h33, "R4", "command seen by device", 64'(dev_cmd), 64'h33);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", 64'(done), 64'd0);
        repeat (50) @(negedge clk);
        chk(done_cnt - d0 == 1, "R9", "done pulses per transaction", 64'(done_cnt - d0), 64'd1);
        chk(dev_id == e_id && family == e_fam && check_byte == e_chk && crc_ok == e_ok,
            "R10", "results held while idle", 64'(dev_id), 64'(e_id));
        chk(bus_drive_low == 1'b0, "R1", "line released when idle", 64'(bus_drive_low), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {62'd0, busy, done}, 64'd0);
        chk(bus_drive_low == 1'b0, "R1", "reset drive", 64'(bus_drive_low), 64'd0);
        chk(no_device == 1'b0 && crc_ok == 1'b0, "R1", "reset flags", {62'd0, no_device, crc_ok}, 64'd0);
        chk(dev_id == '0 && family == '0 && check_byte == '0, "R1", "reset results", 64'(dev_id), 64'd0);
        mon_on = 1'b1;
        // Present device, mixed pattern, valid check byte.
        run_seq(1'b1, 8'h01, 48'h8012_FF00_3CA5, 1'b1, 1'b0);
        // Corrupted check byte, plus a start pulse while busy.
        run_seq(1'b1, 8'h28, 48'h5A69_C3E1_0F96, 1'b0, 1'b1);
        // No device answers: full schedule still runs.
        run_seq(1'b0, 8'h01, 48'h0000_0000_0001, 1'b1, 1'b0);
        // All-zero identifier, presence flag clears again.
        run_seq(1'b1, 8'h00, 48'h0, 1'b1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule